// File: doc/BRIEF.md
# HDLC receive frame error classifier

This block sits behind the zero-bit removal stage of a bit-serial HDLC receiver. It sees one strobe per de-stuffed data bit, plus single-cycle indications that a flag or an abort sequence was found. From these it works out where each frame starts and ends, counts the bits between the flags, and gives every frame a verdict when it closes. An external FCS checker supplies a match indication that is valid when the closing flag arrives. The verdict is one of the following: good, FCS mismatch, misaligned payload, aborted, too long or too short.

The verdict comes out as a single-cycle done pulse with a 4-bit error code and a discard flag. The code is meant to be placed in bits 19:16 of a status word further downstream. When the discard flag is set, the payload must not be written to memory. The maximum frame length is programmed in octets. The short-frame threshold follows the FCS width, which is selectable between 16 and 32 bits. If a frame runs past the maximum length, it is cut off at the bit that crosses the limit. The block then ignores everything until the next flag or abort.

Top module: `hdlc_rx_classifier`

## Requirements
- R1: After reset, done_o, err_code_o and discard_o are all 0.
- R2: Each frame gets exactly one done_o pulse, one cycle wide, in the cycle after its terminating event. A flag or abort with no data bits counted since the opening flag produces no pulse.
- R3: A frame closes on a flag with more bits than the FCS width, a bit count that is a multiple of 8 and crc_ok_i high. It reports code 0 (4'b0000).
- R4: A frame closes on a flag with more bits than the FCS width, a bit count that is a multiple of 8 and crc_ok_i low. It reports the FCS error code 9 (4'b1001).
- R5: A frame with more bits than the FCS width and a bit count that is not a multiple of 8 reports the alignment code 10 (4'b1010), whatever crc_ok_i is. Code 9 is never reported for it.
- R6: An abort inside an open frame with at least one bit reports code 11 (4'b1011). The block then hunts: data bits are ignored until the next flag opens a frame.
- R7: The counted bit may take the length above 8 × max_len_i bits. In that case code 12 (4'b1100) is reported in the next cycle. All bits up to the next flag or abort are then ignored, with no further pulse. A flag ends this state and opens a new frame; an abort ends it and starts hunting.
- R8: A frame closes on a flag with a bit count of at most 16 (fcs32_i=0) or 32 (fcs32_i=1). It reports the short code 13 (4'b1101). This code takes priority over codes 10 and 9.
- R9: discard_o is 1 with codes 12 and 13 and 0 with every other code.
- R10: Before the first flag after reset, and after an abort, data bits and aborts produce no pulse. Every flag restarts the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_valid_i | input | 1 | One de-stuffed data bit received this cycle |
| flag_i | input | 1 | Octet-aligned flag detected this cycle |
| abort_i | input | 1 | Abort sequence (seven 1s) detected this cycle |
| crc_ok_i | input | 1 | External FCS check matches; sampled with flag_i |
| fcs32_i | input | 1 | 1 selects a 32-bit FCS, 0 a 16-bit FCS |
| max_len_i | input | MAXLEN_W | Maximum frame length in octets |
| done_o | output | 1 | One-cycle pulse: a classification is presented |
| err_code_o | output | 4 | Classification code, valid with done_o |
| discard_o | output | 1 | Payload must not be stored, valid with done_o |

## Verification
The assertions take for granted that flag_i and abort_i are never high together. They also assume that neither is ever high in the same cycle as bit_valid_i, since flag and abort bits are not data bits. The bench keeps to this by issuing exactly one event per cycle: a data bit, a flag, an abort, or an idle cycle. This holds in both the directed frames and the randomised frame mix. The crc_ok_i input is only given meaning in the cycle of a closing flag. The bench varies it freely elsewhere to show that it is ignored.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [3:0] {
    ERR_NONE  = 4'd0,
    ERR_FCS   = 4'd9,
    ERR_ALIGN = 4'd10,
    ERR_ABORT = 4'd11,
    ERR_LONG  = 4'd12,
    ERR_SHORT = 4'd13
  } err_code_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_OPEN = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;

  localparam int unsigned FCS_NARROW_BITS = 16;
  localparam int unsigned FCS_WIDE_BITS   = 32;

endpackage

// File: rtl/hdlc_len_counter.sv
module hdlc_len_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             over_next_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  // saturate rather than wrap
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_inc;
  end

  assign cnt_o       = cnt_q;
  assign zero_o      = (cnt_q == '0);
  assign over_next_o = (cnt_inc > limit_i);

endmodule

// File: rtl/hdlc_frame_ctrl.sv
module hdlc_frame_ctrl
  import hdlc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic abort_i,
  input  logic bit_valid_i,
  input  logic cnt_zero_i,
  input  logic over_next_i,
  output logic clear_o,
  output logic inc_o,
  output logic close_o,
  output logic abort_evt_o,
  output logic long_evt_o
);

  rx_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    clear_o     = 1'b0;
    inc_o       = 1'b0;
    close_o     = 1'b0;
    abort_evt_o = 1'b0;
    long_evt_o  = 1'b0;
    if (flag_i) begin
      clear_o = 1'b1;
      close_o = (state_q == ST_OPEN) && !cnt_zero_i;
      state_d = ST_OPEN;
    end else if (abort_i) begin
      clear_o     = 1'b1;
      abort_evt_o = (state_q == ST_OPEN) && !cnt_zero_i;
      state_d     = ST_HUNT;
    end else if (bit_valid_i && state_q == ST_OPEN) begin
      if (over_next_i) begin
        long_evt_o = 1'b1;
        clear_o    = 1'b1;
        state_d    = ST_DROP;
      end else begin
        inc_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/hdlc_err_encode.sv
module hdlc_err_encode
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             close_i,
  input  logic             abort_i,
  input  logic             long_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wide_fcs_i,
  input  logic             crc_ok_i,
  output logic             valid_o,
  output err_code_e        code_o,
  output logic             discard_o
);

  logic [CNT_W-1:0] short_thr;

  assign short_thr = wide_fcs_i ? CNT_W'(FCS_WIDE_BITS) : CNT_W'(FCS_NARROW_BITS);

  // fixed priority: short > align > fcs
  always_comb begin
    code_o = ERR_NONE;
    if (long_i)                     code_o = ERR_LONG;
    else if (abort_i)               code_o = ERR_ABORT;
    else if (cnt_i <= short_thr)    code_o = ERR_SHORT;
    else if (cnt_i[2:0] != 3'd0)    code_o = ERR_ALIGN;
    else if (!crc_ok_i)             code_o = ERR_FCS;
  end

  assign valid_o   = close_i | abort_i | long_i;
  assign discard_o = (code_o == ERR_LONG) || (code_o == ERR_SHORT);

endmodule

// File: rtl/hdlc_rx_classifier.sv
module hdlc_rx_classifier
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned MAXLEN_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_valid_i,
  input  logic                flag_i,
  input  logic                abort_i,
  input  logic                crc_ok_i,
  input  logic                fcs32_i,
  input  logic [MAXLEN_W-1:0] max_len_i,
  output logic                done_o,
  output logic [3:0]          err_code_o,
  output logic                discard_o
);

  localparam int unsigned CNT_W = MAXLEN_W + 4;

  logic [CNT_W-1:0] limit_bits;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero, over_next;
  logic             clear, inc, close_evt, abort_evt, long_evt;
  logic             enc_valid, enc_discard;
  err_code_e        enc_code;

  assign limit_bits = {1'b0, max_len_i, 3'b000};

  hdlc_len_counter #(.CNT_W(CNT_W)) u_len (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .inc_i       (inc),
    .limit_i     (limit_bits),
    .cnt_o       (cnt),
    .zero_o      (cnt_zero),
    .over_next_o (over_next)
  );

  hdlc_frame_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flag_i      (flag_i),
    .abort_i     (abort_i),
    .bit_valid_i (bit_valid_i),
    .cnt_zero_i  (cnt_zero),
    .over_next_i (over_next),
    .clear_o     (clear),
    .inc_o       (inc),
    .close_o     (close_evt),
    .abort_evt_o (abort_evt),
    .long_evt_o  (long_evt)
  );

  hdlc_err_encode #(.CNT_W(CNT_W)) u_enc (
    .close_i    (close_evt),
    .abort_i    (abort_evt),
    .long_i     (long_evt),
    .cnt_i      (cnt),
    .wide_fcs_i (fcs32_i),
    .crc_ok_i   (crc_ok_i),
    .valid_o    (enc_valid),
    .code_o     (enc_code),
    .discard_o  (enc_discard)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      err_code_o <= 4'd0;
      discard_o  <= 1'b0;
    end else begin
      done_o <= enc_valid;
      if (enc_valid) begin
        err_code_o <= enc_code;
        discard_o  <= enc_discard;
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_classifier_chk.sv
module hdlc_rx_classifier_chk #(
  parameter int unsigned MAXLEN_W = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bit_valid_i,
  input logic                flag_i,
  input logic                abort_i,
  input logic                crc_ok_i,
  input logic                fcs32_i,
  input logic [MAXLEN_W-1:0] max_len_i,
  input logic                done_o,
  input logic [3:0]          err_code_o,
  input logic                discard_o
);

  // input assumptions
  p_evt_excl_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_i && abort_i) && !(bit_valid_i && (flag_i || abort_i)));

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_pulse_needs_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_i || abort_i || bit_valid_i) |=> !done_o);

  p_code_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_code_o == 4'd0) || (err_code_o >= 4'd9 && err_code_o <= 4'd13));

  p_close_codes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i |=> !done_o || (err_code_o != 4'd11 && err_code_o != 4'd12));

  p_abort_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !done_o || err_code_o == 4'd11);

  p_long_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> !done_o || err_code_o == 4'd12);

  p_discard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> discard_o == (err_code_o == 4'd12 || err_code_o == 4'd13));

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !done_o && err_code_o == 4'd0 && !discard_o);

  logic unused_ok;
  assign unused_ok = ^{crc_ok_i, fcs32_i, max_len_i};

endmodule

bind hdlc_rx_classifier hdlc_rx_classifier_chk #(.MAXLEN_W(MAXLEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_valid_i (bit_valid_i),
  .flag_i      (flag_i),
  .abort_i     (abort_i),
  .crc_ok_i    (crc_ok_i),
  .fcs32_i     (fcs32_i),
  .max_len_i   (max_len_i),
  .done_o      (done_o),
  .err_code_o  (err_code_o),
  .discard_o   (discard_o)
);

// File: tb/hdlc_rx_classifier_bench.sv
module hdlc_rx_classifier_bench;

  localparam int MAXLEN_W = 12;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                bit_valid = 1'b0, flag = 1'b0, abort_s = 1'b0, crc_ok = 1'b0, fcs32 = 1'b0;
  logic [MAXLEN_W-1:0] max_len = 12'd8;
  logic                done;
  logic [3:0]          code;
  logic                discard;

  always #5 clk = ~clk;

  hdlc_rx_classifier #(.MAXLEN_W(MAXLEN_W)) u_hdlc_rx_classifier (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bit_valid_i (bit_valid),
    .flag_i      (flag),
    .abort_i     (abort_s),
    .crc_ok_i    (crc_ok),
    .fcs32_i     (fcs32),
    .max_len_i   (max_len),
    .done_o      (done),
    .err_code_o  (code),
    .discard_o   (discard)
  );

  int    checks = 0, errors = 0;
  bit    finished = 1'b0;
  string tag = "R2";

  // reference model state: 0 hunt, 1 open, 2 drop
  int    m_mode = 0, m_cnt = 0;
  bit    e_done;
  int    e_code;
  bit    e_disc;
  string e_req;

  task automatic model(input bit v, input bit f, input bit a, input bit c);
    int thr;
    e_done = 1'b0;
    thr = fcs32 ? 32 : 16;
    if (f) begin
      if (m_mode == 1 && m_cnt > 0) begin
        e_done = 1'b1;
        if (m_cnt <= thr)        begin e_code = 13; e_req = "R8"; end
        else if (m_cnt % 8 != 0) begin e_code = 10; e_req = "R5"; end
        else if (!c)             begin e_code = 9;  e_req = "R4"; end
        else                     begin e_code = 0;  e_req = "R3"; end
      end
      m_mode = 1; m_cnt = 0;
    end else if (a) begin
      if (m_mode == 1 && m_cnt > 0) begin
        e_done = 1'b1; e_code = 11; e_req = "R6";
      end
      m_mode = 0; m_cnt = 0;
    end else if (v && m_mode == 1) begin
      m_cnt++;
      if (m_cnt > int'(max_len) * 8) begin
        e_done = 1'b1; e_code = 12; e_req = "R7";
        m_mode = 2; m_cnt = 0;
      end
    end
    if (e_done) e_disc = (e_code == 12 || e_code == 13);
  endtask

  task automatic step(input bit v, input bit f, input bit a, input bit c);
    bit_valid = v; flag = f; abort_s = a; crc_ok = c;
    model(v, f, a, c);
    @(negedge clk);
    checks++;
    if (done !== e_done) begin
      errors++;
      $display("FAIL %s done actual=%0b expected=%0b", tag, done, e_done);
    end
    if (e_done) begin
      checks++;
      if (code !== 4'(e_code)) begin
        errors++;
        $display("FAIL %s code actual=%0d expected=%0d", e_req, code, e_code);
      end
      checks++;
      if (discard !== e_disc) begin
        errors++;
        $display("FAIL R9 discard actual=%0b expected=%0b (code %0d)", discard, e_disc, e_code);
      end
    end
  endtask

  task automatic bits(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0, i[0]);
      if (gaps && i % 5 == 2) step(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic close(input bit c);
    step(1'b0, 1'b1, 1'b0, c);
  endtask

  task automatic abort_ev();
    step(1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic frame(input int n, input bit c);
    bits(n, 1'b0);
    close(c);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (done !== 1'b0 || code !== 4'd0 || discard !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%0b/%0d/%0b expected=0/0/0", done, code, discard);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R10 hunt: bits and aborts before first flag
    tag = "R10";
    bits(20, 1'b1);
    abort_ev();
    bits(5, 1'b0);
    close(1'b1);   // opening flag, no pulse

    // R2 back-to-back flags: zero bits, no pulse
    tag = "R2";
    close(1'b1);
    close(1'b0);

    // R3 good, R4 fcs, R5 align with both crc values
    tag = "R3"; frame(40, 1'b1);
    tag = "R4"; frame(48, 1'b0);
    tag = "R5"; frame(41, 1'b0);
    frame(43, 1'b1);

    // R8 short thresholds, narrow then wide
    tag = "R8";
    frame(16, 1'b1);
    frame(3, 1'b0);
    frame(17, 1'b0);     // just above narrow threshold -> align
    fcs32 = 1'b1;
    frame(24, 1'b1);
    frame(32, 1'b0);
    frame(33, 1'b1);     // above wide threshold -> align
    frame(40, 1'b1);
    fcs32 = 1'b0;

    // R6 abort inside frame, then bits ignored until flag
    tag = "R6";
    bits(10, 1'b1);
    abort_ev();
    bits(12, 1'b0);
    abort_ev();
    close(1'b1);

    // R7 long: exact limit is fine, one more bit overflows
    tag = "R7";
    frame(64, 1'b1);
    bits(65, 1'b0);
    bits(30, 1'b1);
    close(1'b0);         // ends drop, opens new frame, no pulse
    frame(48, 1'b1);
    bits(70, 1'b0);
    abort_ev();          // ends drop into hunt, no pulse
    bits(9, 1'b0);
    close(1'b1);
    max_len = 12'd3;
    frame(24, 1'b1);
    bits(25, 1'b1);
    close(1'b1);
    max_len = 12'd8;

    // mixed frames
    tag = "R2";
    for (int k = 0; k < 300; k++) begin
      int n, kind;
      n = $urandom_range(0, 80);
      kind = $urandom_range(0, 3);
      if (k % 37 == 0) fcs32 = ~fcs32;
      bits(n, kind[0]);
      if (kind == 3) begin
        abort_ev();
        if (n % 2 == 0) bits(4, 1'b0);
        close(1'b1);
      end else begin
        close($urandom_range(0, 1) == 1);
      end
      if (k % 11 == 0) step(1'b0, 1'b0, 1'b0, 1'b1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule